// File: doc/BRIEF.md
# Versatile Interface Adapter Timer

This block is a byte-wide peripheral with sixteen registers behind a 4-bit register select. It provides two 8-bit general-purpose ports, each with its own direction register, and a 16-bit down-counting interval timer. The timer is fed from a pair of reload latches and drives an interrupt flag. Interrupt flag and enable registers combine into one active-low interrupt request. Software typically sets the direction registers to all outputs and puts the timer into free-running mode. It then enables the timer interrupt and writes the timer high byte, which starts a periodic interrupt. For example, a reload value of 0x4FE7 gives roughly 50 Hz from a 1.023 MHz clock.

The bus is synchronous: a chip select qualifies a read or a write strobe in the same cycle. Read data is returned combinationally in that cycle. Register offsets 8, 9, 10 and 12 are plain read/write storage with no effect on the rest of the block. Offset 11 is the auxiliary control byte, and only its bit 6 has an effect.

Top module: `via_timer`

## Requirements
- R1: After reset, both direction registers, the auxiliary control byte, the enable bits and the flag bits are zero, `irqN` is high and the counter is idle at zero.
- R2: Offset 0 is port B, offset 1 is port A and offset 15 is a second view of port A. Offset 2 holds direction B and offset 3 holds direction A. A direction bit of 1 drives the pin from the output register and a 0 makes it an input. A port read returns the output register bit for output pins and the input pin for input pins.
- R3: Writing offset 4 or offset 6 stores only the low latch and writing offset 7 stores only the high latch. None of these writes changes the counter. Offsets 6 and 7 read back the latches.
- R4: Writing offset 5 stores the high latch and loads the counter with {written byte, low latch}. It clears flag bit 6, even when an underflow falls in the same cycle, and starts the timer. Offsets 4 and 5 read the counter low and high bytes.
- R5: A running counter decrements by one per clock. The clock after it reaches zero is an underflow, which sets flag bit 6.
- R6: With auxiliary control bit 6 set (free-running), an underflow reloads the counter from the latches. The flag is then set every N+1 clocks, where N is the latch value.
- R7: With auxiliary control bit 6 clear (one-shot), an underflow wraps the counter to 0xFFFF and it keeps counting. The flag is set only once per write of offset 5.
- R8: Writing offset 13 clears each flag whose data bit is 1. An underflow in the same cycle wins over such a clear. Reading offset 13 returns bit 7 as the OR of all flags that are both set and enabled.
- R9: Writing offset 14 with bit 7 set sets each enable bit whose data bit is 1, and with bit 7 clear it clears them. Reading offset 14 returns bit 7 as 1.
- R10: `irqN` is low exactly when some flag is both set and enabled.
- R11: Reading offset 4 clears flag bit 6.
- R12: Offsets 8, 9, 10 and 12 read back what was written and affect neither the timer nor `irqN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading |
| portAIn | input | 8 | Port A input pins |
| portBIn | input | 8 | Port B input pins |
| portAOut | output | 8 | Port A output register |
| portBOut | output | 8 | Port B output register |
| portAOe | output | 8 | Port A per-pin output enable |
| portBOe | output | 8 | Port B per-pin output enable |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bench times the interrupt edge to the exact clock in both timer modes. A design with an off-by-one period raises the request a cycle early or late. A one-shot timer that re-arms raises a second interrupt after the counter wraps, and the bench waits a full 65536-cycle wrap to catch it. The bench also places a flag clear and an underflow on the same clock edge. A design that lets the clear win misses that interrupt. It also places a high-byte write on an underflow edge, where a design that lets the underflow win leaves the request asserted. Mixed direction masks on port reads catch a design that returns the output register for input pins. An enable write with bit 7 clear, followed by reads of the flag and enable registers, catches a design that sets enables instead of clearing them.

// File: rtl/via_pkg.sv
package via_pkg;
  localparam int REG_AW = 4;
  localparam int NREG = 1 << REG_AW;

  // Register offsets
  localparam logic [REG_AW-1:0] OFS_PB     = 4'h0;
  localparam logic [REG_AW-1:0] OFS_PA     = 4'h1;
  localparam logic [REG_AW-1:0] OFS_DDRB   = 4'h2;
  localparam logic [REG_AW-1:0] OFS_DDRA   = 4'h3;
  localparam logic [REG_AW-1:0] OFS_T1LO   = 4'h4;
  localparam logic [REG_AW-1:0] OFS_T1HI   = 4'h5;
  localparam logic [REG_AW-1:0] OFS_LATLO  = 4'h6;
  localparam logic [REG_AW-1:0] OFS_LATHI  = 4'h7;
  localparam logic [REG_AW-1:0] OFS_AUX    = 4'hB;
  localparam logic [REG_AW-1:0] OFS_FLAG   = 4'hD;
  localparam logic [REG_AW-1:0] OFS_ENAB   = 4'hE;
  localparam logic [REG_AW-1:0] OFS_PANH   = 4'hF;

  localparam int FLAG_T1  = 6;  // timer flag / enable bit
  localparam int AUX_CONT = 6;  // free-running select bit

  // Offsets that are plain storage (timer 2, shift, aux, peripheral control)
  function automatic logic isPlainOfs(input int o);
    return (o == 8) || (o == 9) || (o == 10) || (o == 11) || (o == 12);
  endfunction

  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic            rdT1Lo;
    logic            t1Load;
    logic            t1Dec;
    logic            t1Reload;
    logic            t1Wrap;
    logic            t1Fire;
  } viaStrobes_t;
endpackage

// File: rtl/via_ctrl.sv
module via_ctrl
  import via_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              contMode,
  output viaStrobes_t       strb
);
  logic [NREG-1:0] wrSel;
  logic running;
  logic armed;
  logic cntZero;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign wrSel[g] = cs && wr && (addr == REG_AW'(g));
  end

  assign cntZero = (cntVal == '0);

  always_comb begin
    strb        = '0;
    strb.wrSel  = wrSel;
    strb.rdT1Lo = cs && rd && !wr && (addr == OFS_T1LO);
    strb.t1Load = wrSel[OFS_T1HI];
    if (running && !strb.t1Load) begin
      if (cntZero) begin
        strb.t1Fire   = contMode || armed;
        strb.t1Reload = contMode;
        strb.t1Wrap   = !contMode;
      end else begin
        strb.t1Dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      armed   <= 1'b0;
    end else if (strb.t1Load) begin
      running <= 1'b1;
      armed   <= 1'b1;
    end else if (strb.t1Fire && !contMode) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/via_dp.sv
module via_dp
  import via_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cs,
  input  logic                rd,
  input  logic [REG_AW-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  viaStrobes_t         strb,
  input  logic [DATA_W-1:0]   portAIn,
  input  logic [DATA_W-1:0]   portBIn,
  output logic [DATA_W-1:0]   portAOut,
  output logic [DATA_W-1:0]   portBOut,
  output logic [DATA_W-1:0]   portAOe,
  output logic [DATA_W-1:0]   portBOe,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] cntVal,
  output logic                contMode,
  output logic                irqN
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int SRC_W = DATA_W - 1;

  logic [DATA_W-1:0] ora, orb, ddra, ddrb, latLo, latHi;
  logic [DATA_W-1:0] pinA, pinB;
  logic [CNT_W-1:0]  cnt;
  logic [SRC_W-1:0]  ifr, ifrNext, ier;
  logic [NREG-1:0][DATA_W-1:0] plainRd;
  logic anyIrq;

  // Per-pin direction mux
  for (genvar b = 0; b < DATA_W; b++) begin : g_pin
    assign pinA[b] = ddra[b] ? ora[b] : portAIn[b];
    assign pinB[b] = ddrb[b] ? orb[b] : portBIn[b];
  end

  // Plain storage bytes
  for (genvar g = 0; g < NREG; g++) begin : g_plain
    if (isPlainOfs(g)) begin : g_st
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              q <= '0;
        else if (strb.wrSel[g]) q <= wdata;
      end
      assign plainRd[g] = q;
    end else begin : g_none
      assign plainRd[g] = '0;
    end
  end

  assign contMode = plainRd[OFS_AUX][AUX_CONT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ora <= '0; orb <= '0; ddra <= '0; ddrb <= '0;
      latLo <= '0; latHi <= '0;
    end else begin
      if (strb.wrSel[OFS_PA] || strb.wrSel[OFS_PANH]) ora <= wdata;
      if (strb.wrSel[OFS_PB])   orb  <= wdata;
      if (strb.wrSel[OFS_DDRA]) ddra <= wdata;
      if (strb.wrSel[OFS_DDRB]) ddrb <= wdata;
      if (strb.wrSel[OFS_T1LO] || strb.wrSel[OFS_LATLO]) latLo <= wdata;
      if (strb.wrSel[OFS_T1HI] || strb.wrSel[OFS_LATHI]) latHi <= wdata;
    end
  end

  // Interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.t1Load)   cnt <= {wdata, latLo};
    else if (strb.t1Reload) cnt <= {latHi, latLo};
    else if (strb.t1Wrap)   cnt <= '1;
    else if (strb.t1Dec)    cnt <= cnt - CNT_W'(1);
  end
  assign cntVal = cnt;

  // Flags: set wins over any clear in the same cycle
  always_comb begin
    ifrNext = ifr;
    if (strb.wrSel[OFS_FLAG])          ifrNext = ifrNext & ~wdata[SRC_W-1:0];
    if (strb.rdT1Lo || strb.t1Load)    ifrNext[FLAG_T1] = 1'b0;
    if (strb.t1Fire)                   ifrNext[FLAG_T1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifr <= '0;
      ier <= '0;
    end else begin
      ifr <= ifrNext;
      if (strb.wrSel[OFS_ENAB])
        ier <= wdata[DATA_W-1] ? (ier | wdata[SRC_W-1:0]) : (ier & ~wdata[SRC_W-1:0]);
    end
  end

  assign anyIrq = |(ifr & ier);
  assign irqN   = !anyIrq;

  assign portAOut = ora;
  assign portBOut = orb;
  assign portAOe  = ddra;
  assign portBOe  = ddrb;

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      unique case (addr)
        OFS_PB:            rdata = pinB;
        OFS_PA, OFS_PANH:  rdata = pinA;
        OFS_DDRB:          rdata = ddrb;
        OFS_DDRA:          rdata = ddra;
        OFS_T1LO:          rdata = cnt[DATA_W-1:0];
        OFS_T1HI:          rdata = cnt[CNT_W-1:DATA_W];
        OFS_LATLO:         rdata = latLo;
        OFS_LATHI:         rdata = latHi;
        OFS_FLAG:          rdata = {anyIrq, ifr};
        OFS_ENAB:          rdata = {1'b1, ier};
        default:           rdata = plainRd[addr];
      endcase
    end
  end
endmodule

// File: rtl/via_timer.sv
module via_timer
  import via_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] portAIn,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portBOut,
  output logic [DATA_W-1:0] portAOe,
  output logic [DATA_W-1:0] portBOe,
  output logic              irqN
);
  localparam int CNT_W = 2 * DATA_W;

  viaStrobes_t      strb;
  logic [CNT_W-1:0] cntVal;
  logic             contMode;

  via_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .cntVal(cntVal), .contMode(contMode), .strb(strb)
  );

  via_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .addr(addr), .wdata(wdata),
    .strb(strb), .portAIn(portAIn), .portBIn(portBIn),
    .portAOut(portAOut), .portBOut(portBOut),
    .portAOe(portAOe), .portBOe(portBOe),
    .rdata(rdata), .cntVal(cntVal), .contMode(contMode), .irqN(irqN)
  );
endmodule

// File: rtl/via_timer_chk.sv
module via_timer_chk
  import via_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                cs,
  input logic                wr,
  input logic [REG_AW-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic                irqN,
  input logic [DATA_W-1:0]   portAOe,
  input logic [2*DATA_W-1:0] cntVal,
  input viaStrobes_t         strb
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int SRC_W = DATA_W - 1;

  p_ier_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wr && addr == OFS_ENAB && wdata == {1'b0, {SRC_W{1'b1}}}) |=> irqN);

  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wr && addr == OFS_T1HI) |=> irqN);

  p_load_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.t1Load |=> (cntVal[CNT_W-1:DATA_W] == $past(wdata)));

  p_dec_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.t1Dec |=> (cntVal == $past(cntVal) - CNT_W'(1)));

  p_fire_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.t1Fire |-> (cntVal == '0));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.t1Wrap |=> (cntVal == '1));

  p_ddr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && wr && addr == OFS_DDRA) |=> $stable(portAOe));

  p_wr_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel));
endmodule

bind via_timer via_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
  .irqN(irqN), .portAOe(portAOe), .cntVal(cntVal), .strb(strb)
);

// File: tb/via_timer_test.sv
module via_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, portAIn = '0, portBIn = '0;
  logic [7:0] rdata, portAOut, portBOut, portAOe, portBOe;
  logic       irqN;
  logic       probeEn = 1'b0;
  int         total = 0, bad = 0;
  bit         done = 0;

  typedef struct {
    int         kind;   // 0 rdata, 1 irqN, 2 A oe, 3 A out, 4 B oe, 5 B out
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  via_timer uut (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .portAIn(portAIn), .portBIn(portBIn),
    .portAOut(portAOut), .portBOut(portBOut), .portAOe(portAOe),
    .portBOe(portBOe), .irqN(irqN)
  );

  always #2.5ns clk = ~clk;

  // Driver tasks: one bus cycle each, launched at a falling edge
  task automatic step();
    @(negedge clk); cs = 0; rd = 0; wr = 0; probeEn = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic busWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; rd = 0; addr = a; wdata = d; probeEn = 0;
  endtask
  task automatic busRd(input logic [3:0] a, input logic [7:0] e, input string r);
    item_t it;
    @(negedge clk); cs = 1; rd = 1; wr = 0; addr = a; probeEn = 1;
    it.kind = 0; it.exp = e; it.req = r; sb.push_back(it);
  endtask
  task automatic probe(input int k, input logic [7:0] e, input string r);
    item_t it;
    @(negedge clk); cs = 0; rd = 0; wr = 0; probeEn = 1;
    it.kind = k; it.exp = e; it.req = r; sb.push_back(it);
  endtask

  // Monitor: samples mid-cycle, pops and compares
  always @(negedge clk) begin
    #1ns;
    if (probeEn) begin
      item_t it;
      logic [7:0] act;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL monitor: no expected item queued, actual rdata=%h", rdata);
      end else begin
        it = sb.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = {7'b0, irqN};
          2: act = portAOe;
          3: act = portAOut;
          4: act = portBOe;
          default: act = portBOut;
        endcase
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    probe(1, 8'h01, "R1");
    busRd(4'h3, 8'h00, "R1");
    busRd(4'h2, 8'h00, "R1");
    busRd(4'hB, 8'h00, "R1");
    busRd(4'hE, 8'h80, "R1 R9");
    busRd(4'hD, 8'h00, "R1");
    probe(2, 8'h00, "R1");
    // R2: ports and direction
    busWr(4'h3, 8'hF0);
    busWr(4'h1, 8'hA5);
    portAIn = 8'h3C;
    busRd(4'h1, 8'hAC, "R2");
    busRd(4'hF, 8'hAC, "R2");
    probe(2, 8'hF0, "R2");
    probe(3, 8'hA5, "R2");
    busWr(4'h2, 8'hFF);
    busWr(4'h0, 8'h5A);
    probe(4, 8'hFF, "R2");
    busRd(4'h0, 8'h5A, "R2");
    busWr(4'h2, 8'h00);
    portBIn = 8'h77;
    busRd(4'h0, 8'h77, "R2");
    probe(5, 8'h5A, "R2");
    // R12: plain storage
    busWr(4'h8, 8'h9A);
    busWr(4'h9, 8'h44);
    busWr(4'hA, 8'h33);
    busWr(4'hC, 8'h71);
    busRd(4'h8, 8'h9A, "R12");
    busRd(4'h9, 8'h44, "R12");
    busRd(4'hA, 8'h33, "R12");
    busRd(4'hC, 8'h71, "R12");
    busRd(4'h4, 8'h00, "R12");
    probe(1, 8'h01, "R12");
    // R3: latch-only writes
    busWr(4'h4, 8'h05);
    busRd(4'h6, 8'h05, "R3");
    busRd(4'h4, 8'h00, "R3");
    busWr(4'h7, 8'h12);
    busRd(4'h7, 8'h12, "R3");
    busRd(4'h5, 8'h00, "R3");
    // One-shot, N = 5
    busWr(4'hB, 8'h00);
    busWr(4'hE, 8'hC0);
    busRd(4'hE, 8'hC0, "R9");
    busWr(4'h5, 8'h00);          // n0
    busRd(4'h4, 8'h05, "R4");    // n0+1
    busRd(4'h5, 8'h00, "R4");    // n0+2
    busRd(4'h7, 8'h00, "R4");    // n0+3
    idle(2);                     // n0+4..5
    probe(1, 8'h01, "R5");       // n0+6: counter at zero
    probe(1, 8'h00, "R5 R10");   // n0+7: underflow seen
    busRd(4'hD, 8'hC0, "R8");    // n0+8
    busRd(4'h4, 8'hFD, "R7");    // n0+9: wrapped and counting
    probe(1, 8'h01, "R11");      // n0+10
    busRd(4'h5, 8'hFF, "R7");    // n0+11
    idle(65600);
    probe(1, 8'h01, "R7");       // no second one-shot interrupt
    // Free-running, N = 3
    busWr(4'hB, 8'h40);
    busRd(4'hB, 8'h40, "R6");
    busWr(4'h4, 8'h03);
    busWr(4'h5, 8'h00);          // n1
    idle(3);
    probe(1, 8'h01, "R6");       // n1+4
    probe(1, 8'h00, "R6");       // n1+5
    busWr(4'hD, 8'h40);          // n1+6
    probe(1, 8'h01, "R8");       // n1+7
    probe(1, 8'h01, "R6");       // n1+8
    probe(1, 8'h00, "R6");       // n1+9
    busRd(4'h4, 8'h02, "R6");    // n1+10: reloaded then decremented
    step();                      // n1+11
    busWr(4'hD, 8'h40);          // n1+12: clear meets underflow
    probe(1, 8'h00, "R8");       // n1+13
    busWr(4'hE, 8'h7F);          // n1+14
    probe(1, 8'h01, "R10");      // n1+15
    busRd(4'hD, 8'h40, "R8");    // n1+16
    busRd(4'hE, 8'h80, "R9");    // n1+17
    busWr(4'hE, 8'hC0);          // n1+18
    probe(1, 8'h00, "R10");      // n1+19
    busWr(4'h5, 8'h00);          // n1+20: load meets underflow
    probe(1, 8'h01, "R4");       // n1+21
    step();
    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule